// File: doc/BRIEF.md
# Transfer Length Command Splitter

This block turns one byte-count request into the series of command words that a serial-flash command queue needs to move that many bytes. Software or a sequencer hands it a length of up to 2^LEN_W-1 bytes, a base command word and a rounding option. The base word carries the bus, chip-select, direction and lane-mode bits. The block then presents one command word per accepted handshake on a valid/ready output stream. Next to each word it gives the number of data bytes that word will move, so a data mover downstream can size its own work.

Counts of 256 bytes or more are encoded as powers of two. The block emits one exponent word for each set bit of the length at position 8 or above, lowest bit first. Any leftover below 256 goes into a single immediate-count word at the end. For receive transfers into a word-aligned sink, the immediate count can be rounded up to a multiple of four. If that rounding would reach 256, the block emits an exponent word of 8 in its place.

Back-pressure: once `ent_valid` is high, the word and its byte count stay unchanged until the cycle in which `ent_ready` is also high. A word is consumed only on a cycle where both are high. `req_start` is a plain one-cycle strobe. It is accepted only while `busy` is low.

Top module: `len_splitter`

## Requirements
- R1: A request with length zero emits no command word; `done` is high in the cycle after the accepting edge and `busy` stays low.
- R2: While the remaining length is above 255, the next word has bit 9 (exponent flag) set and bits [7:0] equal to the lowest set bit position e >= 8 of the remaining length; exponent words therefore come out in ascending e, and 2^e is removed from the remaining length.
- R3: When the remaining length is 1..255, exactly one final word is emitted with bit 9 clear and bits [7:0] equal to that remainder; when it is zero after the exponent words, no immediate word follows.
- R4: Every emitted word has bit 8 (data-transfer flag) set, and bits [CMD_W-1:10] equal to those of `req_base` captured at acceptance; bits [9:0] of `req_base` have no effect.
- R5: `ent_bytes` equals 2^e for an exponent word and the value of bits [7:0] for an immediate word.
- R6: With `req_round4` high, a non-zero immediate remainder that is not a multiple of 4 is rounded up to the next multiple of 4; if the result is 256, an exponent word with e = 8 is emitted instead, and it is the last word.
- R7: While `ent_valid` is high and `ent_ready` low, `ent_valid`, `ent_word` and `ent_bytes` hold their values in the next cycle.
- R8: `done` is high for the one cycle after the edge on which the last word is accepted; `busy` is low and `ent_valid` is low in that cycle, and `ent_valid` is never high while `busy` is low.
- R9: A `req_start` strobe while `busy` is high is ignored: the word sequence in progress is unchanged.
- R10: After reset `busy`, `done` and `ent_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_len | input | LEN_W | Requested byte count |
| req_base | input | CMD_W | Base command word; bits [CMD_W-1:10] copied to every entry |
| req_round4 | input | 1 | Round the immediate remainder up to a multiple of 4 |
| busy | output | 1 | A split is in progress |
| done | output | 1 | One-cycle pulse when the request is complete |
| ent_valid | output | 1 | Command word available |
| ent_ready | input | 1 | Consumer accepts the word |
| ent_word | output | CMD_W | Command word |
| ent_bytes | output | LEN_W | Data bytes moved by this word |

## Verification
The hardest cases to reach are the rounding edge, where a remainder of 253 to 255 turns into an exponent word, and lengths that are exact powers of two, where the last word is an exponent word and no immediate word follows. The bench sweeps every length of a 12-bit configuration, both with and without rounding, so every mix of high bits and remainder occurs. It applies random back-pressure throughout. On some requests it also fires a second strobe with a different length while the first split is still in progress.

// File: rtl/len_splitter_pkg.sv
package len_splitter_pkg;
  localparam int FIELD_W   = 8;   // width of the count / exponent field
  localparam int XFER_BIT  = 8;   // data-transfer flag position
  localparam int EXP_BIT   = 9;   // exponent flag position
  localparam int CTRL_LSB  = 10;  // first bit copied from the base word
  localparam int IMM_LIMIT = 255; // largest immediate count
  localparam int EXP_MIN   = 8;   // smallest exponent ever emitted
endpackage

// File: rtl/len_splitter_scan.sv
// Finds the lowest set bit at or above EXP_MIN in the remaining length.
module len_splitter_scan
  import len_splitter_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]   rem,
  output logic               hi_nz,
  output logic [FIELD_W-1:0] exp_idx
);
  always_comb begin
    hi_nz   = 1'b0;
    exp_idx = FIELD_W'(EXP_MIN);
    for (int k = LEN_W - 1; k >= EXP_MIN; k--) begin
      if (rem[k]) begin
        hi_nz   = 1'b1;
        exp_idx = FIELD_W'(k);
      end
    end
  end
endmodule

// File: rtl/len_splitter_fmt.sv
// Builds the current command word, its byte count and the next remainder.
module len_splitter_fmt
  import len_splitter_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CMD_W = 20
) (
  input  logic [LEN_W-1:0]   rem,
  input  logic [CMD_W-1:0]   base,
  input  logic               round4,
  input  logic               hi_nz,
  input  logic [FIELD_W-1:0] exp_idx,
  output logic [CMD_W-1:0]   word,
  output logic [LEN_W-1:0]   bytes,
  output logic               last,
  output logic [LEN_W-1:0]   rem_next
);
  logic [FIELD_W:0]   imm_raw;
  logic [FIELD_W:0]   imm_up;
  logic               use_exp;
  logic [FIELD_W-1:0] field;

  always_comb begin
    imm_raw = {1'b0, rem[FIELD_W-1:0]};
    imm_up  = round4 ? ((imm_raw + (FIELD_W+1)'(3)) & ~(FIELD_W+1)'(3)) : imm_raw;

    if (hi_nz) begin
      use_exp = 1'b1;
      field   = exp_idx;
      bytes   = LEN_W'(1) << exp_idx;
      last    = (rem == bytes);
    end else if (imm_up[FIELD_W]) begin
      use_exp = 1'b1;
      field   = FIELD_W'(EXP_MIN);
      bytes   = LEN_W'(1) << EXP_MIN;
      last    = 1'b1;
    end else begin
      use_exp = 1'b0;
      field   = imm_up[FIELD_W-1:0];
      bytes   = LEN_W'(imm_up);
      last    = 1'b1;
    end

    rem_next = last ? '0 : (rem - bytes);

    word                          = '0;
    word[CMD_W-1:CTRL_LSB]        = base[CMD_W-1:CTRL_LSB];
    word[EXP_BIT]                 = use_exp;
    word[XFER_BIT]                = 1'b1;
    word[FIELD_W-1:0]             = field;
  end
endmodule

// File: rtl/len_splitter.sv
module len_splitter
  import len_splitter_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CMD_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [LEN_W-1:0] req_len,
  input  logic [CMD_W-1:0] req_base,
  input  logic             req_round4,
  output logic             busy,
  output logic             done,
  output logic             ent_valid,
  input  logic             ent_ready,
  output logic [CMD_W-1:0] ent_word,
  output logic [LEN_W-1:0] ent_bytes
);
  logic               busy_q;
  logic               done_q;
  logic               r4_q;
  logic [LEN_W-1:0]   rem_q;
  logic [CMD_W-1:0]   base_q;
  logic               hi_nz;
  logic [FIELD_W-1:0] exp_idx;
  logic               last;
  logic [LEN_W-1:0]   rem_next;
  logic               take;

  len_splitter_scan #(.LEN_W(LEN_W)) u_scan (
    .rem     (rem_q),
    .hi_nz   (hi_nz),
    .exp_idx (exp_idx)
  );

  len_splitter_fmt #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_fmt (
    .rem      (rem_q),
    .base     (base_q),
    .round4   (r4_q),
    .hi_nz    (hi_nz),
    .exp_idx  (exp_idx),
    .word     (ent_word),
    .bytes    (ent_bytes),
    .last     (last),
    .rem_next (rem_next)
  );

  assign take = busy_q && ent_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      r4_q   <= 1'b0;
      rem_q  <= '0;
      base_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_start) begin
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            rem_q  <= req_len;
            base_q <= req_base;
            r4_q   <= req_round4;
          end
        end
      end else if (take) begin
        rem_q <= rem_next;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign ent_valid = busy_q;
endmodule

// File: rtl/len_splitter_chk.sv
module len_splitter_chk #(
  parameter int LEN_W = 16,
  parameter int CMD_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             ent_valid,
  input logic             ent_ready,
  input logic [CMD_W-1:0] ent_word,
  input logic [LEN_W-1:0] ent_bytes,
  input logic             r4
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_word) && $stable(ent_bytes));

  p_xfer_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_word[8]);

  p_exp_bytes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_word[9] |-> ($countones(ent_bytes) == 1) && (ent_bytes >= LEN_W'(256)));

  p_imm_bytes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_word[9] |-> (ent_bytes == LEN_W'(ent_word[7:0])) && (ent_bytes != '0));

  p_round_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && r4 && !ent_word[9] |-> ent_word[1:0] == 2'b00);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ent_valid);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind len_splitter len_splitter_chk #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .ent_valid (ent_valid),
  .ent_ready (ent_ready),
  .ent_word  (ent_word),
  .ent_bytes (ent_bytes),
  .r4        (r4_q)
);

// File: tb/len_splitter_bench.sv
module len_splitter_bench;
  localparam int LEN_W = 12;
  localparam int CMD_W = 16;
  localparam int MAXE  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_start = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [CMD_W-1:0] req_base = '0;
  logic             req_round4 = 1'b0;
  logic             busy, done, ent_valid;
  logic             ent_ready = 1'b0;
  logic [CMD_W-1:0] ent_word;
  logic [LEN_W-1:0] ent_bytes;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [CMD_W-1:0] exp_w [MAXE];
  logic [LEN_W-1:0] exp_b [MAXE];
  int               exp_n;

  always #4 clk = ~clk;

  len_splitter #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_len_splitter (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_len(req_len),
    .req_base(req_base), .req_round4(req_round4), .busy(busy), .done(done),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_word(ent_word),
    .ent_bytes(ent_bytes)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [CMD_W-1:0] mk(input logic [CMD_W-1:0] base, input bit ex, input int f);
    return (base & 16'hFC00) | 16'h0100 | (ex ? 16'h0200 : 16'h0000) | CMD_W'(f);
  endfunction

  // Expected sequence, from R2, R3, R5, R6
  task automatic model(input int len, input bit r4, input logic [CMD_W-1:0] base);
    int rem;
    rem = len;
    exp_n = 0;
    while (rem > 0) begin
      if (rem > 255) begin
        int k;
        k = 8;
        while (((rem >> k) & 1) == 0) k++;
        exp_w[exp_n] = mk(base, 1'b1, k);
        exp_b[exp_n] = LEN_W'(1 << k);
        rem = rem - (1 << k);
      end else begin
        int v;
        v = r4 ? ((rem + 3) / 4) * 4 : rem;
        if (v == 256) begin
          exp_w[exp_n] = mk(base, 1'b1, 8);
          exp_b[exp_n] = LEN_W'(256);
        end else begin
          exp_w[exp_n] = mk(base, 1'b0, v);
          exp_b[exp_n] = LEN_W'(v);
        end
        rem = 0;
      end
      exp_n++;
    end
  endtask

  task automatic run(input int len, input bit r4, input logic [CMD_W-1:0] base, input bit inject);
    int idx;
    bit rdy;
    bit injected;
    model(len, r4, base);
    @(negedge clk);
    req_start  = 1'b1;
    req_len    = LEN_W'(len);
    req_base   = base;
    req_round4 = r4;
    @(negedge clk);
    req_start = 1'b0;
    if (len == 0) begin
      check(done === 1'b1 && ent_valid === 1'b0 && busy === 1'b0, "R1", {done, ent_valid, busy}, 3'b100);
      return;
    end
    idx = 0;
    injected = 0;
    while (idx < exp_n) begin
      check(ent_valid === 1'b1 && done === 1'b0, "R8", {ent_valid, done}, 2'b10);
      check(ent_word === exp_w[idx], exp_w[idx][9] ? "R2/R4" : "R3/R4", ent_word, exp_w[idx]);
      check(ent_bytes === exp_b[idx], r4 ? "R5/R6" : "R5", ent_bytes, exp_b[idx]);
      rdy = ($urandom_range(0, 2) != 0);
      ent_ready = rdy;
      if (inject && !injected) begin
        // R9: strobe while busy with a different request
        req_start = 1'b1;
        req_len   = LEN_W'(len ^ 12'h5A5);
        req_base  = ~base;
        req_round4 = ~r4;
        injected = 1;
      end
      @(negedge clk);
      req_start = 1'b0;
      if (rdy) idx++;
      else check(ent_valid === 1'b1 && ent_word === exp_w[idx], "R7", ent_word, exp_w[idx]);
    end
    ent_ready = 1'b0;
    check(done === 1'b1 && busy === 1'b0 && ent_valid === 1'b0, "R8", {done, busy, ent_valid}, 3'b100);
    if (inject) begin
      @(negedge clk);
      check(done === 1'b0 && ent_valid === 1'b0, "R9", {done, ent_valid}, 2'b00);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && ent_valid === 1'b0, "R10", {busy, done, ent_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && ent_valid === 1'b0, "R10", {busy, ent_valid}, 0);
    // Corner cases first: exact powers of two, rounding edge
    run(256, 1'b0, 16'hA7FF, 1'b0);
    run(2048, 1'b1, 16'h1234, 1'b0);
    run(253, 1'b1, 16'h5C00, 1'b0);
    run(509, 1'b1, 16'hF3FF, 1'b0);
    run(0, 1'b1, 16'hFFFF, 1'b0);
    // Full sweep of the small configuration
    for (int r = 0; r < 2; r++) begin
      for (int l = 0; l < (1 << LEN_W); l++) begin
        run(l, r[0], CMD_W'($urandom), (l % 7) == 3);
      end
    end
    finish_run();
  end
endmodule